// File: doc/BRIEF.md
# Flash Block Write-Protection Gate

This block sits between a flash command decoder and the program/erase engine. For each program or erase request it decides, one clock later, whether the operation may touch the addressed block. Two active-low hardware pins guard two disjoint regions. The boot pin guards the top block only. The general pin guards every other block. A per-block software lock bit decides only where neither pin is asserted. A refused request is simply never granted. Nothing is reported, and the gate stays idle.

When a request is granted, an operation begins. The gate freezes its copy of both pins until the engine reports completion on `op_done_i`. Any request checked during that window uses the frozen values, so a pin that moves mid-operation changes nothing. Software lock bits are loaded through a write port, eight blocks per group write.

Top module: `wp_gate`

## Requirements
- R1: After reset `allow_o` and `busy_o` are 0 and every lock bit is 0, so with both pins high every block accepts requests.
- R2: `allow_o` is high for exactly the cycle after a clock edge that samples a permitted request, and it is low after any edge where `req_valid_i` is 0.
- R3: While the effective boot pin is low, a request whose block index (address bits [17:14]) is 15 is refused, whatever its lock bit holds.
- R4: The boot pin has no effect on requests to blocks 0 to 14.
- R5: While the effective general pin is low, requests to blocks 0 to 14 are refused, whatever their lock bits hold. This pin has no effect on block 15.
- R6: Where no pin protects the block, a lock bit of 1 refuses the request and a lock bit of 0 permits it.
- R7: A write with `lock_we_i`=1 replaces the lock bits of group `lock_grp_i`. Bit j of `lock_wdata_i` becomes the lock of block 8*`lock_grp_i`+j, and the other group is unchanged.
- R8: Op codes are 2'b01 byte program, 2'b10 sector erase and 2'b11 block erase. Each is checked against the block that contains its address. Code 2'b00 is never permitted and never starts an operation.
- R9: A permitted request while idle raises `busy_o` from the next cycle and captures both pins. A refused request leaves `busy_o` low.
- R10: While `busy_o` is high, requests are judged with the captured pins and live pin changes are ignored. `op_done_i` drops `busy_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | Operation code |
| req_addr_i | input | 18 | Target byte address |
| boot_lock_ni | input | 1 | Boot block protect pin, active low |
| wr_prot_ni | input | 1 | Protect pin for blocks 0..14, active low |
| lock_we_i | input | 1 | Lock group write strobe |
| lock_grp_i | input | 1 | Lock group select |
| lock_wdata_i | input | 8 | Lock bits for the selected group |
| op_done_i | input | 1 | Operation finished |
| allow_o | output | 1 | Request permitted (registered) |
| busy_o | output | 1 | Operation in progress |

## Verification
Every decision is registered once. A request driven before edge k therefore shows on `allow_o` after edge k, and the bench samples it at the following falling edge. `busy_o` rises at the same edge as the grant, and it falls at the edge that samples `op_done_i`. The bench samples both one half period after the edge. A lock write is committed at its edge and takes effect only for requests sampled at later edges, so the bench never overlaps a lock write with a request. The sweep covers every block, every op code, all four pin combinations and two complementary lock patterns. Each pass releases the operation before the next request.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  localparam int unsigned NUM_BLK = 16;
  localparam int unsigned OFS_W   = 14;
  localparam int unsigned GRP_SZ  = 8;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_PROG   = 2'b01,
    OP_SECT_E = 2'b10,
    OP_BLK_E  = 2'b11
  } op_e;
endpackage

// File: rtl/wp_lock_regs.sv
module wp_lock_regs #(
  parameter int unsigned NUM_BLK   = 16,
  parameter int unsigned GRP_SZ    = 8,
  parameter int unsigned NUM_GRP   = NUM_BLK / GRP_SZ,
  parameter int unsigned GRP_IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [GRP_IDX_W-1:0] grp_i,
  input  logic [GRP_SZ-1:0]    wdata_i,
  output logic [NUM_BLK-1:0]   lock_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lock_o[g*GRP_SZ +: GRP_SZ] <= '0;
      else if (we_i && grp_i == GRP_IDX_W'(g)) lock_o[g*GRP_SZ +: GRP_SZ] <= wdata_i;
    end
  end
endmodule

// File: rtl/wp_pin_hold.sv
module wp_pin_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic boot_n_i,
  input  logic prot_n_i,
  output logic busy_o,
  output logic held_boot_n_o,
  output logic held_prot_n_o,
  output logic eff_boot_n_o,
  output logic eff_prot_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o        <= 1'b0;
      held_boot_n_o <= 1'b1;
      held_prot_n_o <= 1'b1;
    end else if (busy_o) begin
      if (done_i) busy_o <= 1'b0;
    end else if (start_i) begin
      busy_o        <= 1'b1;
      held_boot_n_o <= boot_n_i;
      held_prot_n_o <= prot_n_i;
    end
  end

  // frozen copy governs decisions for the whole operation
  assign eff_boot_n_o = busy_o ? held_boot_n_o : boot_n_i;
  assign eff_prot_n_o = busy_o ? held_prot_n_o : prot_n_i;
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_gate_pkg::*;
#(
  parameter int unsigned NUM_BLK   = 16,
  parameter int unsigned BLK_IDX_W = $clog2(NUM_BLK)
) (
  input  op_e                  op_i,
  input  logic [BLK_IDX_W-1:0] blk_i,
  input  logic [NUM_BLK-1:0]   lock_i,
  input  logic                 boot_n_i,
  input  logic                 prot_n_i,
  output logic                 ok_o
);
  localparam logic [BLK_IDX_W-1:0] BOOT_BLK = BLK_IDX_W'(NUM_BLK - 1);

  logic is_boot, pin_prot;

  always_comb begin
    is_boot  = (blk_i == BOOT_BLK);
    pin_prot = is_boot ? !boot_n_i : !prot_n_i;
    ok_o     = (op_i != OP_NONE) && !pin_prot && !lock_i[blk_i];
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_gate_pkg::*;
#(
  parameter int unsigned N_BLK     = wp_gate_pkg::NUM_BLK,
  parameter int unsigned BLK_OFS_W = wp_gate_pkg::OFS_W,
  parameter int unsigned LOCK_GRP  = wp_gate_pkg::GRP_SZ,
  parameter int unsigned BLK_IDX_W = $clog2(N_BLK),
  parameter int unsigned ADDR_W    = BLK_IDX_W + BLK_OFS_W,
  parameter int unsigned N_GRP     = N_BLK / LOCK_GRP,
  parameter int unsigned GRP_IDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 boot_lock_ni,
  input  logic                 wr_prot_ni,
  input  logic                 lock_we_i,
  input  logic [GRP_IDX_W-1:0] lock_grp_i,
  input  logic [LOCK_GRP-1:0]  lock_wdata_i,
  input  logic                 op_done_i,
  output logic                 allow_o,
  output logic                 busy_o
);
  logic [BLK_IDX_W-1:0] blk;
  logic [N_BLK-1:0]     lock_bits;
  logic                 held_boot_n, held_prot_n, eff_boot_n, eff_prot_n;
  logic                 ok, start;
  logic                 unused_ofs;

  assign blk        = req_addr_i[ADDR_W-1:BLK_OFS_W];
  assign unused_ofs = ^req_addr_i[BLK_OFS_W-1:0];

  wp_lock_regs #(
    .NUM_BLK(N_BLK), .GRP_SZ(LOCK_GRP), .NUM_GRP(N_GRP), .GRP_IDX_W(GRP_IDX_W)
  ) u_locks (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lock_we_i), .grp_i(lock_grp_i),
    .wdata_i(lock_wdata_i), .lock_o(lock_bits)
  );

  wp_pin_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .done_i(op_done_i),
    .boot_n_i(boot_lock_ni), .prot_n_i(wr_prot_ni), .busy_o(busy_o),
    .held_boot_n_o(held_boot_n), .held_prot_n_o(held_prot_n),
    .eff_boot_n_o(eff_boot_n), .eff_prot_n_o(eff_prot_n)
  );

  wp_decide #(.NUM_BLK(N_BLK), .BLK_IDX_W(BLK_IDX_W)) u_dec (
    .op_i(op_e'(req_op_i)), .blk_i(blk), .lock_i(lock_bits),
    .boot_n_i(eff_boot_n), .prot_n_i(eff_prot_n), .ok_o(ok)
  );

  assign start = req_valid_i && ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) allow_o <= 1'b0;
    else         allow_o <= start;
  end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned BLK_OFS_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              boot_lock_ni,
  input logic              wr_prot_ni,
  input logic              op_done_i,
  input logic              allow_o,
  input logic              busy_o,
  input logic              held_boot_n,
  input logic              held_prot_n
);
  localparam int unsigned BW = ADDR_W - BLK_OFS_W;
  logic [BW-1:0] blk;
  logic          top_blk;
  assign blk     = req_addr_i[ADDR_W-1:BLK_OFS_W];
  assign top_blk = &blk;

  assert_idle_no_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !allow_o);
  assert_boot_pin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !boot_lock_ni && top_blk) |=> !allow_o);
  assert_prot_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !wr_prot_ni && !top_blk) |=> !allow_o);
  assert_nop_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_op_i == 2'b00) |=> !allow_o);
  assert_busy_from_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> allow_o);
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !op_done_i) |=> busy_o);
  assert_pins_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(held_boot_n) && $stable(held_prot_n)));
  assert_done_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_done_i) |=> !busy_o);
endmodule

bind wp_gate wp_gate_chk #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_addr_i(req_addr_i), .boot_lock_ni(boot_lock_ni), .wr_prot_ni(wr_prot_ni),
  .op_done_i(op_done_i), .allow_o(allow_o), .busy_o(busy_o),
  .held_boot_n(held_boot_n), .held_prot_n(held_prot_n)
);

// File: tb/sim_wp_gate.sv
module sim_wp_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'b00;
  logic [17:0] req_addr_i = '0;
  logic        boot_lock_ni = 1'b1;
  logic        wr_prot_ni = 1'b1;
  logic        lock_we_i = 1'b0;
  logic [0:0]  lock_grp_i = 1'b0;
  logic [7:0]  lock_wdata_i = '0;
  logic        op_done_i = 1'b0;
  logic        allow_o, busy_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] lock_m = '0;

  always #10 clk_i = ~clk_i;

  wp_gate u0 (.*);

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_lock(input logic g, input logic [7:0] d);
    @(negedge clk_i);
    lock_we_i = 1'b1; lock_grp_i = g; lock_wdata_i = d;
    @(negedge clk_i);
    lock_we_i = 1'b0;
    lock_m[g*8 +: 8] = d;
  endtask

  // drive one request; sample grant and busy half a period after the edge
  task automatic req(input logic [1:0] op, input int b, output logic got, output logic bsy);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op;
    req_addr_i = {b[3:0], 14'(b * 777 + 5)};
    @(negedge clk_i);
    req_valid_i = 1'b0; req_op_i = 2'b00;
    got = allow_o; bsy = busy_o;
  endtask

  task automatic finish_op();
    @(negedge clk_i);
    op_done_i = 1'b1;
    @(negedge clk_i);
    op_done_i = 1'b0;
  endtask

  function automatic logic model(input logic [1:0] op, input int b, input logic t, input logic w);
    logic pin_ok;
    pin_ok = (b == 15) ? t : w;
    return (op != 2'b00) && pin_ok && !lock_m[b];
  endfunction

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic got, bsy, e;
    repeat (3) @(negedge clk_i);
    check("R1", allow_o, 1'b0);
    check("R1", busy_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", allow_o, 1'b0);
    // R1: all blocks unlocked after reset
    for (int b = 0; b < 16; b++) begin
      req(2'b01, b, got, bsy);
      check("R1", got, 1'b1);
      finish_op();
    end
    // R2: no request, no grant
    @(negedge clk_i);
    check("R2", allow_o, 1'b0);

    // R3 R4 R5 R6 R8 R9: sweep pins, locks, blocks, op codes
    for (int pat = 0; pat < 2; pat++) begin
      write_lock(1'b0, pat ? 8'h5A : 8'hA5);
      write_lock(1'b1, pat ? 8'h3C : 8'hC3);
      for (int pins = 0; pins < 4; pins++) begin
        boot_lock_ni = pins[0]; wr_prot_ni = pins[1];
        for (int b = 0; b < 16; b++) begin
          for (int op = 0; op < 4; op++) begin
            e = model(op[1:0], b, pins[0], pins[1]);
            req(op[1:0], b, got, bsy);
            if (op == 0) check("R8", got, 1'b0);
            else if (b == 15) check(pins[0] ? "R6" : "R3", got, e);
            else check(pins[1] ? "R4" : "R5", got, e);
            check("R9", bsy, e);
            if (bsy) finish_op();
            @(negedge clk_i);
            check("R2", allow_o, 1'b0);
          end
        end
      end
    end

    // R7: group write leaves the other group untouched
    boot_lock_ni = 1'b1; wr_prot_ni = 1'b1;
    write_lock(1'b0, 8'h00);
    write_lock(1'b1, 8'hFF);
    write_lock(1'b0, 8'h02);
    req(2'b11, 1, got, bsy); check("R7", got, 1'b0);
    req(2'b11, 0, got, bsy); check("R7", got, 1'b1); finish_op();
    req(2'b10, 9, got, bsy); check("R7", got, 1'b0);
    write_lock(1'b1, 8'h00);
    req(2'b10, 9, got, bsy); check("R7", got, 1'b1); finish_op();

    // R10: frozen pins during an operation
    req(2'b01, 3, got, bsy); check("R9", bsy, 1'b1);
    @(negedge clk_i);
    wr_prot_ni = 1'b0; boot_lock_ni = 1'b0;
    req(2'b01, 3, got, bsy);  check("R10", got, 1'b1);
    req(2'b10, 15, got, bsy); check("R10", got, 1'b1);
    check("R10", bsy, 1'b1);
    finish_op();
    check("R10", busy_o, 1'b0);
    req(2'b01, 3, got, bsy);  check("R10", got, 1'b0);
    check("R10", bsy, 1'b0);
    // captured low pins persist while live pins go high
    wr_prot_ni = 1'b1; boot_lock_ni = 1'b0;
    req(2'b01, 4, got, bsy); check("R9", bsy, 1'b1);
    boot_lock_ni = 1'b1;
    req(2'b11, 15, got, bsy); check("R10", got, 1'b0);
    finish_op();
    req(2'b11, 15, got, bsy); check("R10", got, 1'b1);
    finish_op();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule